// File: doc/BRIEF.md
# I2C Master START Generator with Collision Check

This block produces the START condition for an I2C master and watches for a second master on the same bus while it does so. It controls the open-drain SDA and SCL lines through two output enables, where 1 means the line is pulled low. It reads both lines back through a two-flop synchronizer. A down-counting timer sets the length of each phase, and a 7-bit reload value gives its half-period. Each phase lasts `max(reload, 1)` clocks.

A request starts the sequence. It first checks that the bus is free, then counts out the first phase with both lines released, then pulls SDA low. It counts a second phase and then pulls SCL low, which completes the START. If another master pulls SDA low first, the block shortens the first phase and pulls SDA low at once. If SCL drops while SDA is still high, the block treats that as a lost bus: it releases both lines, sets a sticky collision flag and returns to idle.

`startReq` is a level. After the START completes, both lines stay low for as long as the request stays high. When the request is dropped, both lines are released.

Top module: `i2c_start_gen`

## Requirements
- R1: After reset both output enables are 0, `startDone` and `collFlag` are 0, and `idleState` is 1.
- R2: If a request arrives in idle while either synchronized line reads low, `collFlag` is set on that clock edge, the block stays idle, and neither line is driven.
- R3: With both lines high, SDA is driven low (`sdaOe`=1) exactly N clocks after the request edge, where N = `reloadVal`, or 1 when `reloadVal` is 0.
- R4: SCL is driven low (`sclOe`=1) exactly N clocks after SDA. `startDone` is high for that one cycle only.
- R5: If the synchronized SCL reads low while SDA reads high during the first phase, `collFlag` is set, both enables return to 0 and `idleState` becomes 1.
- R6: A line change reaches the control logic on the third clock edge after it occurs (two-flop synchronizer). If another master pulls SDA low during the first phase, `sdaOe` rises on that edge without a collision, and the second phase still lasts a full N clocks.
- R7: SCL read low during the second phase is not a collision. The START completes on schedule.
- R8: `collFlag` stays set until `clearColl` is high on a clock edge. While it is set, a request is ignored: no line is driven and `idleState` stays 1.
- R9: A reload value of 0 gives phases of exactly one clock each.
- R10: After completion both enables stay 1 while `startReq` stays high. One edge after the request drops, both are 0 and `idleState` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Level request for a START |
| clearColl | input | 1 | Clears the collision flag |
| reloadVal | input | 7 | Phase length in clocks (0 acts as 1) |
| sdaIn | input | 1 | SDA line as seen on the pad |
| sclIn | input | 1 | SCL line as seen on the pad |
| sdaOe | output | 1 | 1 pulls SDA low |
| sclOe | output | 1 | 1 pulls SCL low |
| startDone | output | 1 | One-cycle pulse when the START completes |
| collFlag | output | 1 | Sticky bus-collision flag |
| idleState | output | 1 | 1 while the generator is idle |

## Verification
Counting from the edge that samples the request, `sdaOe` is due N edges later and `sclOe` with `startDone` 2N edges later. A collision or an early SDA caused by a line change shows up on the third edge after that change, and release follows one edge after the request drops. Each scenario task drives its inputs 1 ns after a rising edge. It then steps a counted number of edges and samples both on the cycle before a result is due, where it must still be absent, and on the cycle it is due. This pins each event to one exact edge rather than a window.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_SDA_WAIT = 2'd1,
    ST_SCL_WAIT = 2'd2,
    ST_HOLD     = 2'd3
  } phase_e;

  typedef struct packed {
    logic load;
    logic dec;
  } cntCmd_t;

endpackage

// File: rtl/i2c_start_sync.sv
module i2c_start_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] rawIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[STAGES-2:0], rawIn[b]};
    end
    assign syncOut[b] = pipe[STAGES-1];
  end
endmodule

// File: rtl/i2c_start_dp.sv
module i2c_start_dp
  import i2c_start_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCmd_t          cmd,
  input  logic [CNT_W-1:0] reloadVal,
  output logic             cntLast
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] effReload;

  assign effReload = (reloadVal == '0) ? ONE : reloadVal;
  assign cntLast   = (cnt == ONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (cmd.load) cnt <= effReload;
    else if (cmd.dec && cnt != '0) cnt <= cnt - ONE;
  end

  // R3 / R9: a freshly loaded phase never starts at zero
  a_r9_load_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> cnt != '0);

  // R3: the counter steps down by one per enabled cycle
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.dec && !cmd.load && cnt != '0) |=> cnt == $past(cnt) - ONE);

endmodule

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
  import i2c_start_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    clearColl,
  input  logic    sdaS,
  input  logic    sclS,
  input  logic    cntLast,
  output cntCmd_t cmd,
  output logic    sdaOe,
  output logic    sclOe,
  output logic    startDone,
  output logic    collFlag,
  output logic    idleState
);
  phase_e state, nxt;
  logic   setColl;
  logic   doneNxt;

  always_comb begin
    nxt     = state;
    cmd     = '0;
    setColl = 1'b0;
    doneNxt = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startReq && !collFlag) begin
          if (!sdaS || !sclS) begin
            setColl = 1'b1;
          end else begin
            cmd.load = 1'b1;
            nxt      = ST_SDA_WAIT;
          end
        end
      end
      ST_SDA_WAIT: begin
        if (sdaS && !sclS) begin
          setColl = 1'b1;
          nxt     = ST_IDLE;
        end else if (!sdaS || cntLast) begin
          cmd.load = 1'b1;
          nxt      = ST_SCL_WAIT;
        end else begin
          cmd.dec = 1'b1;
        end
      end
      ST_SCL_WAIT: begin
        if (cntLast) begin
          nxt     = ST_HOLD;
          doneNxt = 1'b1;
        end else begin
          cmd.dec = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!startReq) nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      collFlag  <= 1'b0;
      startDone <= 1'b0;
      sdaOe     <= 1'b0;
      sclOe     <= 1'b0;
      idleState <= 1'b1;
    end else begin
      state     <= nxt;
      startDone <= doneNxt;
      sdaOe     <= (nxt == ST_SCL_WAIT) || (nxt == ST_HOLD);
      sclOe     <= (nxt == ST_HOLD);
      idleState <= (nxt == ST_IDLE);
      if (setColl)        collFlag <= 1'b1;
      else if (clearColl) collFlag <= 1'b0;
    end
  end

  a_r4_done_with_scl: assert property (@(posedge clk) disable iff (!rstN)
    startDone |-> (sclOe && sdaOe));

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rstN)
    startDone |=> !startDone);

  a_r4_scl_needs_sda: assert property (@(posedge clk) disable iff (!rstN)
    sclOe |-> sdaOe);

  a_r5_release_on_coll: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collFlag) |-> (!sdaOe && !sclOe && idleState));

  a_r8_ignore_when_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (idleState && collFlag) |=> (idleState && !sdaOe));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (collFlag && !clearColl) |=> collFlag);

  a_r10_release_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    (sclOe && !startReq) |=> (!sclOe && !sdaOe && idleState));

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int RELOAD_W    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startReq,
  input  logic                clearColl,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                sdaIn,
  input  logic                sclIn,
  output logic                sdaOe,
  output logic                sclOe,
  output logic                startDone,
  output logic                collFlag,
  output logic                idleState
);
  localparam int LINES = 2;

  logic [LINES-1:0] lineSync;
  cntCmd_t          cmd;
  logic             cntLast;

  i2c_start_sync #(.STAGES(SYNC_STAGES), .WIDTH(LINES)) uSync (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   ({sclIn, sdaIn}),
    .syncOut (lineSync)
  );

  i2c_start_dp #(.CNT_W(RELOAD_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .reloadVal (reloadVal),
    .cntLast   (cntLast)
  );

  i2c_start_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .clearColl (clearColl),
    .sdaS      (lineSync[0]),
    .sclS      (lineSync[1]),
    .cntLast   (cntLast),
    .cmd       (cmd),
    .sdaOe     (sdaOe),
    .sclOe     (sclOe),
    .startDone (startDone),
    .collFlag  (collFlag),
    .idleState (idleState)
  );
endmodule

// File: tb/i2c_start_gen_test.sv
`timescale 1ns/1ps
module i2c_start_gen_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       clearColl = 1'b0;
  logic [6:0] reloadVal = 7'd4;
  logic       otherSda = 1'b0;
  logic       otherScl = 1'b0;
  logic       sdaOe, sclOe, startDone, collFlag, idleState;
  logic       sdaIn, sclIn;
  int         errors = 0;
  int         checks = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  assign sdaIn = !(sdaOe || otherSda);
  assign sclIn = !(sclOe || otherScl);

  i2c_start_gen uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .clearColl(clearColl),
    .reloadVal(reloadVal), .sdaIn(sdaIn), .sclIn(sclIn),
    .sdaOe(sdaOe), .sclOe(sclOe), .startDone(startDone),
    .collFlag(collFlag), .idleState(idleState)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic request();
    @(negedge clk);
    startReq = 1'b1;
    tick(1);
  endtask

  task automatic releaseReq(input string req);
    startReq = 1'b0;
    tick(1);
    chk(req, "sdaOe released", sdaOe, 1'b0);
    chk(req, "sclOe released", sclOe, 1'b0);
    chk(req, "idle after release", idleState, 1'b1);
    tick(4);
  endtask

  task automatic testReset();
    chk("R1", "sdaOe", sdaOe, 1'b0);
    chk("R1", "sclOe", sclOe, 1'b0);
    chk("R1", "startDone", startDone, 1'b0);
    chk("R1", "collFlag", collFlag, 1'b0);
    chk("R1", "idleState", idleState, 1'b1);
  endtask

  task automatic testNormal(input int r, input string req);
    int n;
    n = (r == 0) ? 1 : r;
    reloadVal = 7'(r);
    request();
    tick(n - 1);
    chk(req, "R3 sdaOe before due", sdaOe, 1'b0);
    tick(1);
    chk(req, "R3 sdaOe due", sdaOe, 1'b1);
    chk(req, "R4 sclOe not yet", sclOe, 1'b0);
    tick(n - 1);
    chk(req, "R4 sclOe before due", sclOe, 1'b0);
    chk(req, "R4 done before due", startDone, 1'b0);
    tick(1);
    chk(req, "R4 sclOe due", sclOe, 1'b1);
    chk(req, "R4 done pulse", startDone, 1'b1);
    tick(1);
    chk(req, "R4 done one cycle", startDone, 1'b0);
    chk(req, "R10 scl held", sclOe, 1'b1);
    chk(req, "R10 sda held", sdaOe, 1'b1);
    chk(req, "no collision", collFlag, 1'b0);
    releaseReq("R10");
  endtask

  task automatic testBusyAtRequest(input bit useSda);
    reloadVal = 7'd4;
    if (useSda) otherSda = 1'b1; else otherScl = 1'b1;
    tick(3);
    request();
    chk("R2", "collFlag set", collFlag, 1'b1);
    chk("R2", "idle kept", idleState, 1'b1);
    tick(6);
    chk("R2", "sdaOe never", sdaOe, 1'b0);
    chk("R2", "sclOe never", sclOe, 1'b0);
    startReq = 1'b0;
    otherSda = 1'b0;
    otherScl = 1'b0;
    tick(4);
  endtask

  task automatic testIgnoreAndClear();
    reloadVal = 7'd3;
    request();
    tick(8);
    chk("R8", "sdaOe ignored", sdaOe, 1'b0);
    chk("R8", "idle kept", idleState, 1'b1);
    chk("R8", "flag sticky", collFlag, 1'b1);
    startReq = 1'b0;
    clearColl = 1'b1;
    tick(1);
    clearColl = 1'b0;
    chk("R8", "flag cleared", collFlag, 1'b0);
    tick(2);
  endtask

  task automatic testSclCollision();
    reloadVal = 7'd20;
    request();
    tick(2);
    otherScl = 1'b1;
    tick(2);
    chk("R5", "no flag before sync", collFlag, 1'b0);
    tick(1);
    chk("R5", "collFlag set", collFlag, 1'b1);
    chk("R5", "idle", idleState, 1'b1);
    chk("R5", "sdaOe released", sdaOe, 1'b0);
    tick(20);
    chk("R5", "sclOe stays released", sclOe, 1'b0);
    startReq = 1'b0;
    otherScl = 1'b0;
    clearColl = 1'b1;
    tick(1);
    clearColl = 1'b0;
    tick(4);
  endtask

  task automatic testEarlySda();
    int n;
    n = 20;
    reloadVal = 7'(n);
    request();
    tick(2);
    otherSda = 1'b1;
    tick(2);
    chk("R6", "sdaOe before sync", sdaOe, 1'b0);
    tick(1);
    chk("R6", "sdaOe early", sdaOe, 1'b1);
    chk("R6", "no collision", collFlag, 1'b0);
    tick(n - 1);
    chk("R6", "sclOe before full phase", sclOe, 1'b0);
    tick(1);
    chk("R6", "sclOe after full phase", sclOe, 1'b1);
    chk("R6", "done", startDone, 1'b1);
    otherSda = 1'b0;
    releaseReq("R6");
  endtask

  task automatic testSclLowPhase2();
    int n;
    n = 10;
    reloadVal = 7'(n);
    request();
    tick(n);
    chk("R7", "sdaOe", sdaOe, 1'b1);
    otherScl = 1'b1;
    tick(n - 1);
    chk("R7", "no collision", collFlag, 1'b0);
    chk("R7", "sclOe before due", sclOe, 1'b0);
    tick(1);
    chk("R7", "sclOe on schedule", sclOe, 1'b1);
    chk("R7", "done on schedule", startDone, 1'b1);
    otherScl = 1'b0;
    releaseReq("R7");
  endtask

  initial begin
    tick(3);
    testReset();
    rstN = 1'b1;
    tick(4);
    testNormal(5, "R3");
    testNormal(0, "R9");
    testNormal(1, "R9");
    testNormal(127, "R3");
    testBusyAtRequest(1'b1);
    testIgnoreAndClear();
    clearColl = 1'b1; tick(1); clearColl = 1'b0;
    testBusyAtRequest(1'b0);
    testIgnoreAndClear();
    testSclCollision();
    testEarlySda();
    testSclLowPhase2();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule